// File: doc/BRIEF.md
# Serial Byte CRC-8 Generator and Checker

This block keeps an 8-bit cyclic redundancy check over the bytes of one message on a vehicle serial data bus. A start-of-message clear presets the remainder. Each byte offered with a valid strobe is then folded into the remainder, most significant bit first, in a single clock cycle. The divisor is x^8 + x^4 + x^3 + x^2 + 1 (0x1D).

When transmitting, the inverted remainder on `crc_out` is the check byte that goes on the line after the last data byte. When receiving, the data bytes and the received check byte all pass through the same division. An intact message always leaves the fixed residue 0xC4. An end-of-data strobe in receive mode judges the remainder. A wrong residue, or a message shorter than one data byte plus its check byte, raises a sticky error flag. Symbol timing, arbitration, line coding and in-frame responses are handled elsewhere.

Top module: `crc8_gen_chk`

## Requirements
- R1: Reset or a `sof_clr` pulse sets the remainder to 0xFF, so `crc_out` reads 0x00 in the next cycle, and it clears `crc_err` and the byte tally.
- R2: Each cycle with `byte_vld` high and `sof_clr` low folds `byte_data` into the remainder with divisor 0x1D, bit 7 first. `crc_out` equals the bitwise inverse of the updated remainder in the following cycle.
- R3: In transmit mode (`mode_rx` = 0), `crc_out` after the data bytes is the check byte to append. For the ASCII bytes "123456789" it is 0x4B.
- R4: In receive mode, feeding the data bytes and then the check byte leaves the remainder at 0xC4, so `crc_out` reads 0x3B.
- R5: An `eod_strb` in receive mode with a remainder other than 0xC4 sets `crc_err` in the next cycle.
- R6: An `eod_strb` in receive mode with a remainder of 0xC4 and at least two bytes since the clear leaves `crc_err` low.
- R7: An `eod_strb` in receive mode after fewer than two bytes since the clear sets `crc_err`, even when the remainder is 0xC4. This includes zero bytes.
- R8: Once set, `crc_err` stays high through later bytes and end-of-data strobes until the next `sof_clr`.
- R9: In transmit mode, `eod_strb` leaves `crc_err` unchanged.
- R10: With neither `byte_vld` nor `sof_clr` high, the remainder holds. When `sof_clr` and `byte_vld` are high together, the clear wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_clr | input | 1 | Start-of-message clear |
| byte_vld | input | 1 | Byte strobe for `byte_data` |
| byte_data | input | 8 | Message byte, bit 7 processed first |
| mode_rx | input | 1 | 1 = receive check, 0 = transmit generate |
| eod_strb | input | 1 | End-of-data strobe; judges the residue in receive mode |
| crc_out | output | 8 | Inverted remainder (transmit check byte) |
| crc_err | output | 1 | Sticky CRC error flag |

## Verification
The error-flag assertions assume that `eod_strb` never arrives in the same cycle as `byte_vld`. The judgement reads the registered remainder and tally, so a byte in that same cycle would not be counted. The stimulus issues every byte, end-of-data strobe and clear as its own operation. The single exception is the deliberate clear-with-byte collision that R10 calls for. Mode changes happen only between messages, and the bench model derives every expected value from a byte-wise form of the division that it computes itself.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

  localparam int unsigned CRC_W = 8;

  typedef logic [CRC_W-1:0] crc_t;

  // One serial division step: shift left, fold in the divisor when the
  // outgoing bit and the incoming message bit differ.
  function automatic crc_t crc8_bit_step(crc_t rem, logic msg_bit, crc_t poly);
    logic fb;
    fb = rem[CRC_W-1] ^ msg_bit;
    return {rem[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Remainder judgement: residue mismatch or too few bytes is an error.
  function automatic logic crc8_judge_bad(crc_t rem, crc_t residue, logic enough);
    return (rem != residue) || !enough;
  endfunction

endpackage

// File: rtl/crc8_shift_engine.sv
module crc8_shift_engine
  import crc8_pkg::*;
#(
  parameter crc_t POLY   = 8'h1D,
  parameter crc_t PRESET = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  crc_t data,
  output crc_t rem
);

  localparam int unsigned STEPS = CRC_W;

  // Unrolled bit chain: stage[0] is the held remainder, stage[STEPS] the
  // remainder after the whole byte.
  crc_t stage [0:STEPS];
  crc_t nxt_rem;

  assign stage[0] = rem;

  generate
    for (genvar i = 0; i < STEPS; i++) begin : g_bit
      assign stage[i+1] = crc8_bit_step(stage[i], data[STEPS-1-i], POLY);
    end
  endgenerate

  assign nxt_rem = stage[STEPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= PRESET;
    end else if (clr) begin
      rem <= PRESET;
    end else if (load) begin
      rem <= nxt_rem;
    end
  end

  // R1: a clear always lands on the preset.
  p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem == PRESET));

  // R10: nothing but a clear or a byte moves the remainder.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(rem));

  // R2: a zero byte into a zero remainder stays zero (linearity of the chain).
  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load && rem == '0 && data == '0) |=> (rem == '0));

endmodule

// File: rtl/crc8_byte_tally.sv
module crc8_byte_tally #(
  parameter int unsigned MIN_BYTES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic enough
);

  localparam int unsigned CNT_W = $clog2(MIN_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

  logic [CNT_W-1:0] cnt;
  logic             at_max;

  assign at_max = (cnt == CNT_MAX);
  assign enough = at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the tally saturates and never passes the minimum length.
  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  // R7: a clear always restarts the count.
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/crc8_residue_judge.sv
module crc8_residue_judge
  import crc8_pkg::*;
#(
  parameter crc_t RESIDUE = 8'hC4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic eod,
  input  logic rx_mode,
  input  crc_t rem,
  input  logic enough,
  output logic err
);

  logic judge_fire;
  logic judge_bad;

  assign judge_fire = eod && rx_mode && !clr;
  assign judge_bad  = crc8_judge_bad(rem, RESIDUE, enough);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (clr) begin
      err <= 1'b0;
    end else if (judge_fire && judge_bad) begin
      err <= 1'b1;
    end
  end

  // R5: a failing judgement raises the flag next cycle.
  p_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (judge_fire && judge_bad) |=> err);

  // R5: the flag rises only after a receive-mode end-of-data.
  p_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(eod && rx_mode));

  // R6: a passing judgement on a clean message keeps the flag low.
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (judge_fire && !judge_bad && !err) |=> !err);

  // R8: the flag is sticky until a clear.
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  // R9: in transmit mode the flag does not move without a clear.
  p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && !clr) |=> $stable(err));

endmodule

// File: rtl/crc8_gen_chk.sv
module crc8_gen_chk
  import crc8_pkg::*;
#(
  parameter logic [7:0] POLY      = 8'h1D,
  parameter logic [7:0] PRESET    = 8'hFF,
  parameter logic [7:0] RESIDUE   = 8'hC4,
  parameter int unsigned MIN_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       mode_rx,
  input  logic       eod_strb,
  output logic [7:0] crc_out,
  output logic       crc_err
);

  crc_t rem_q;
  logic byte_take;
  logic len_ok;

  // A clear in the same cycle drops the byte.
  assign byte_take = byte_vld && !sof_clr;

  crc8_shift_engine #(
    .POLY   (POLY),
    .PRESET (PRESET)
  ) u_engine (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sof_clr),
    .load  (byte_take),
    .data  (byte_data),
    .rem   (rem_q)
  );

  crc8_byte_tally #(
    .MIN_BYTES (MIN_BYTES)
  ) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sof_clr),
    .tick   (byte_take),
    .enough (len_ok)
  );

  crc8_residue_judge #(
    .RESIDUE (RESIDUE)
  ) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sof_clr),
    .eod     (eod_strb),
    .rx_mode (mode_rx),
    .rem     (rem_q),
    .enough  (len_ok),
    .err     (crc_err)
  );

  assign crc_out = ~rem_q;

  // R1: after a clear the port shows the inverted preset and no error.
  p_clr_ports_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sof_clr |=> (crc_out == ~PRESET) && !crc_err);

  // R10: a byte colliding with a clear leaves no trace.
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_clr && byte_vld) |=> (crc_out == ~PRESET));

endmodule

// File: tb/crc8_gen_chk_tb.sv
module crc8_gen_chk_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof_clr = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       mode_rx = 1'b0;
  logic       eod_strb = 1'b0;
  logic [7:0] crc_out;
  logic       crc_err;

  always #10 clk = ~clk;  // 50 MHz

  crc8_gen_chk u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_clr   (sof_clr),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .mode_rx   (mode_rx),
    .eod_strb  (eod_strb),
    .crc_out   (crc_out),
    .crc_err   (crc_err)
  );

  typedef struct {
    logic [7:0] crc;
    logic       err;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // Bench model state
  logic [7:0] m_rem = 8'hFF;
  int         m_cnt = 0;
  logic       m_err = 1'b0;

  // Byte-wise division: xor the byte in, then eight shift steps.
  function automatic logic [7:0] ref_crc(logic [7:0] r, logic [7:0] d);
    logic [7:0] x;
    x = r ^ d;
    for (int k = 0; k < 8; k++) begin
      if (x[7]) x = (x << 1) ^ 8'h1D;
      else      x = x << 1;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: one operation per cycle, expected outputs pushed to the queue.
  task automatic op(input bit clr, input bit vld, input logic [7:0] d,
                    input bit rx, input bit eod, input string tag);
    exp_t e;
    @(negedge clk);
    sof_clr = clr; byte_vld = vld; byte_data = d; mode_rx = rx; eod_strb = eod;
    if (clr) begin
      m_rem = 8'hFF; m_cnt = 0; m_err = 1'b0;
    end else begin
      if (eod && rx && (m_rem != 8'hC4 || m_cnt < 2)) m_err = 1'b1;
      if (vld) begin
        m_rem = ref_crc(m_rem, d);
        m_cnt++;
      end
    end
    @(posedge clk);
    #1;
    e.crc = ~m_rem; e.err = m_err; e.tag = tag;
    exp_q.push_back(e);
    sof_clr = 1'b0; byte_vld = 1'b0; eod_strb = 1'b0;
  endtask

  // Monitor: compare results as they appear.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(crc_out == e.crc, {e.tag, " crc_out"}, crc_out, e.crc);
      check(crc_err == e.err, {e.tag, " crc_err"}, crc_err, e.err);
    end
  end

  task automatic send_msg(input logic [7:0] bytes[$], input bit rx, input string tag);
    foreach (bytes[i]) op(1'b0, 1'b1, bytes[i], rx, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] msg[$];
    logic [7:0] tx_crc;
    logic [7:0] one_b;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(crc_out == 8'h00, "R1 reset crc_out", crc_out, 8'h00);
    check(crc_err == 1'b0, "R1 reset crc_err", crc_err, 0);
    rst_n = 1'b1;

    // R2/R3: transmit "123456789", each byte checked by the scoreboard
    op(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1 clear");
    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_msg(msg, 1'b0, "R2 tx byte");
    @(negedge clk);
    check(crc_out == 8'h4B, "R3 tx check byte", crc_out, 8'h4B);
    tx_crc = crc_out;

    // R10: idle cycles hold the remainder
    repeat (3) @(negedge clk);
    check(crc_out == tx_crc, "R10 idle hold", crc_out, tx_crc);

    // R9: end-of-data in transmit mode with a non-residue remainder
    op(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R9 tx eod");

    // R4/R6: receive the same message plus its check byte
    op(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1 clear rx");
    send_msg(msg, 1'b1, "R2 rx byte");
    op(1'b0, 1'b1, tx_crc, 1'b1, 1'b0, "R4 rx crc byte");
    @(negedge clk);
    check(crc_out == 8'h3B, "R4 residue", crc_out, 8'h3B);
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R6 good eod");

    // R5: corrupted check byte
    op(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1 clear bad");
    send_msg(msg, 1'b1, "R2 rx byte");
    op(1'b0, 1'b1, tx_crc ^ 8'h10, 1'b1, 1'b0, "R5 bad crc byte");
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5 bad eod");
    @(negedge clk);
    check(crc_err == 1'b1, "R5 flag", crc_err, 1);

    // R8: sticky through more bytes and strobes
    op(1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, "R8 byte after err");
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R8 eod after err");
    op(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R8 tx eod after err");
    @(negedge clk);
    check(crc_err == 1'b1, "R8 sticky", crc_err, 1);
    op(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1 clear after err");

    // R7: zero bytes then end-of-data
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R7 empty eod");

    // R7: one byte reaching the residue is still too short
    one_b = 8'h00;
    for (int b = 0; b < 256; b++)
      if (ref_crc(8'hFF, 8'(b)) == 8'hC4) one_b = 8'(b);
    op(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1 clear short");
    op(1'b0, 1'b1, one_b, 1'b1, 1'b0, "R7 single byte");
    @(negedge clk);
    check(crc_out == 8'h3B, "R7 single byte residue", crc_out, 8'h3B);
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R7 short eod");

    // R10: clear wins over a colliding byte
    op(1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, "R2 pre-collision");
    op(1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, "R10 clear with byte");

    // R4/R6: minimum frame and varied messages, generated then checked
    for (int len = 1; len <= 6; len++) begin
      logic [7:0] m[$];
      logic [7:0] r;
      m = {};
      r = 8'hFF;
      for (int i = 0; i < len; i++) begin
        m.push_back(8'((len * 37 + i * 91 + 13) & 8'hFF));
        r = ref_crc(r, m[i]);
      end
      op(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1 clear loop");
      send_msg(m, 1'b1, "R2 loop byte");
      op(1'b0, 1'b1, ~r, 1'b1, 1'b0, "R4 loop crc byte");
      op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R6 loop eod");
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule